// File: doc/BRIEF.md
# Configurable Digital Crosspoint Switch

This block is a routing fabric for a set of pin cells. Each pin has an input path and an output path. Every input value first passes through an input stage and then lands in a shared pool. Any output may take any pool entry, with no restriction to nearby pins. Each output cell chooses at run time among four configured sources, using two select bits that are themselves taken from the pool. The chosen value passes through an output stage. An optional forced level can then replace it, and the result drives the pin together with its own enable.

Each stage, input or output, can pass data straight through, act as a transparent latch, or act as an edge-triggered register. Its clock comes from one of a few dedicated clock inputs or from any raw pin input. The system clock samples these selected clocks. Configuration is shifted in serially into a shadow chain and then copied to the active set in one step. Every pin enable stays off from reset until the first copy, so the block can be inserted into a live system.

Top module: `xpt_fabric`

## Requirements
- R1: Each pin's pool value is its input stage result. Output cell i drives `pin_out[i]` from the pool entry named by its chosen source field. Any index from 0 to NPINS-1 is valid, and an index at or above NPINS gives 0.
- R2: Each cell has four source fields, src0 to src3. The field used is src[2*pool[sel1] + pool[sel0]], where sel1 and sel0 are per-cell pool indices. This choice is re-evaluated every cycle.
- R3: The 2-bit fixed-level field overrides the routed value. Code 2'b11 drives 1 and code 2'b10 drives 0. Codes 2'b00 and 2'b01 let the routed value through.
- R4: The input stage mode and the output stage mode each use the same codes. Code 0 and code 3 pass data straight through. Code 1 is a latch: it is transparent while its gate is high and otherwise holds the value it sampled at the last system clock edge with the gate high. Code 2 is a register: it captures its data at a system clock edge where the gate is high and was low at the previous edge.
- R5: A stage's gate is chosen by a per-stage clock index k. For k < NCLK the gate is `dclk[k]`. For NCLK <= k < NCLK+NPINS it is `pin_in[k-NCLK]`, taken raw. Any higher index gives 0.
- R6: Once configured, pin i is enabled when its constant-enable bit is 1. Otherwise it is enabled when pool[oe_src] XOR its polarity bit equals 1, so a polarity bit of 1 makes the source active low.
- R7: `pin_out` and `pin_oe` are outputs, and a pin is driven only while its `pin_oe` bit is 1. From reset until the first configuration transfer, every `pin_oe` bit is 0. Reset clears all stage state to 0.
- R8: `cfg_din` is shifted in MSB first at each clock edge where `cfg_en` is 1. The frame is NPINS*CB bits, where CB = 8+7*SW+2*CW, SW = clog2(NPINS) and CW = clog2(NCLK+NPINS). Cell i occupies bits [i*CB +: CB]. Within a cell, the fields from bit 0 upward are: oe_pol, oe_const, oe_src (SW bits), fixed level (2 bits), output clock (CW bits), output mode (2), sel0 (SW), sel1 (SW), src0 to src3 (SW each), input clock (CW) and input mode (2). The shadow frame becomes active at the first edge where `cfg_en` is 0 after being 1, and it is seen at the outputs right after that edge.
- R9: While a new frame is being shifted in, the active configuration does not change and the outputs keep following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all stage gates |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data, MSB first |
| dclk | input | NCLK | Dedicated stage clock inputs |
| pin_in | input | NPINS | Input value of each pin |
| pin_out | output | NPINS | Output value of each pin |
| pin_oe | output | NPINS | Output enable of each pin (1 = driven) |

## Verification
The bench builds the fabric with its defaults: NPINS=8 and NCLK=2. This gives 3-bit pool indices that cover exactly the eight pins, and 4-bit clock indices in which six codes fall out of range and must give 0. At this size a 296-bit frame loads in a few hundred cycles, so dozens of random and directed frames fit in the budget. Every mode pairing, every fixed-level code, both enable polarities and reloads over a live configuration are exercised, with every pin compared each cycle against a model in the bench.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;
   typedef enum logic [1:0] {
      XP_COMB     = 2'd0,
      XP_LATCH    = 2'd1,
      XP_REG      = 2'd2,
      XP_COMB_ALT = 2'd3
   } xp_mode_e;

   localparam logic [1:0] XP_FIX_LOW  = 2'b10;
   localparam logic [1:0] XP_FIX_HIGH = 2'b11;

   // bits of configuration held per pin cell
   function automatic int xp_cell_bits(input int sw, input int cw);
      return 8 + 7 * sw + 2 * cw;
   endfunction

   // bits of a cell used by its output side (below the input clock field)
   function automatic int xp_out_bits(input int sw, input int cw);
      return 6 + 7 * sw + cw;
   endfunction
endpackage

// File: rtl/xpt_stage.sv
`timescale 1ns/1ps
module xpt_stage
   import xpt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode,
   input  logic       gate,
   input  logic       d,
   output logic       q
);
   logic hold_q;
   logic gate_q;
   logic capt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         gate_q <= 1'b0;
         capt_q <= 1'b0;
      end else begin
         gate_q <= gate;
         if (gate) hold_q <= d;
         if (gate && !gate_q) capt_q <= d;
      end
   end

   always_comb begin
      case (mode)
         XP_LATCH: q = gate ? d : hold_q;
         XP_REG:   q = capt_q;
         default:  q = d;
      endcase
   end
endmodule

// File: rtl/xpt_cfg_chain.sv
`timescale 1ns/1ps
module xpt_cfg_chain #(
   parameter int TOTAL = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_din,
   output logic [TOTAL-1:0] shadow,
   output logic [TOTAL-1:0] active,
   output logic             valid
);
   logic en_q;

   if (TOTAL < 2) begin : g_bad_total
      $error("xpt_cfg_chain: TOTAL must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
         valid  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         en_q <= cfg_en;
         if (cfg_en) shadow <= {shadow[TOTAL-2:0], cfg_din};
         if (en_q && !cfg_en) begin
            active <= shadow;
            valid  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/xpt_out_cell.sv
`timescale 1ns/1ps
module xpt_out_cell
   import xpt_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int NCLK  = 2,
   localparam int SW   = (NPINS > 1) ? $clog2(NPINS) : 1,
   localparam int CW   = $clog2(NCLK + NPINS),
   localparam int OB   = xp_out_bits(SW, CW)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [OB-1:0]         cfg,
   input  logic [NPINS-1:0]      pool,
   input  logic [NCLK+NPINS-1:0] clk_pool,
   input  logic                  valid,
   output logic                  out,
   output logic                  oe
);
   localparam int OE_SRC_LSB = 2;
   localparam int FIX_LSB    = 2 + SW;
   localparam int OCLK_LSB   = 4 + SW;
   localparam int OMODE_LSB  = 4 + SW + CW;
   localparam int SEL0_LSB   = 6 + SW + CW;
   localparam int SEL1_LSB   = 6 + 2 * SW + CW;
   localparam int SRC0_LSB   = 6 + 3 * SW + CW;

   function automatic logic pick_pool(input logic [NPINS-1:0] v, input logic [SW-1:0] i);
      return (32'(i) < NPINS) ? v[i] : 1'b0;
   endfunction

   function automatic logic pick_clk(input logic [NCLK+NPINS-1:0] v, input logic [CW-1:0] i);
      return (32'(i) < NCLK + NPINS) ? v[i] : 1'b0;
   endfunction

   logic [SW-1:0] src [4];
   logic [SW-1:0] oe_src, sel0, sel1;
   logic [CW-1:0] oclk;
   logic [1:0]    omode, fix;
   logic [1:0]    way;
   logic          routed, gate, staged;

   for (genvar k = 0; k < 4; k++) begin : g_src
      assign src[k] = cfg[SRC0_LSB + k * SW +: SW];
   end

   assign oe_src = cfg[OE_SRC_LSB +: SW];
   assign fix    = cfg[FIX_LSB +: 2];
   assign oclk   = cfg[OCLK_LSB +: CW];
   assign omode  = cfg[OMODE_LSB +: 2];
   assign sel0   = cfg[SEL0_LSB +: SW];
   assign sel1   = cfg[SEL1_LSB +: SW];

   assign way    = {pick_pool(pool, sel1), pick_pool(pool, sel0)};
   assign routed = pick_pool(pool, src[way]);
   assign gate   = pick_clk(clk_pool, oclk);

   xpt_stage u_ostage (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (omode),
      .gate  (gate),
      .d     (routed),
      .q     (staged)
   );

   always_comb begin
      case (fix)
         XP_FIX_HIGH: out = 1'b1;
         XP_FIX_LOW:  out = 1'b0;
         default:     out = staged;
      endcase
   end

   assign oe = valid & (cfg[1] | (pick_pool(pool, oe_src) ^ cfg[0]));
endmodule

// File: rtl/xpt_fabric.sv
`timescale 1ns/1ps
module xpt_fabric
   import xpt_pkg::*;
#(
   parameter int NPINS = 8,
   parameter int NCLK  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_din,
   input  logic [NCLK-1:0]  dclk,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe
);
   localparam int SW        = (NPINS > 1) ? $clog2(NPINS) : 1;
   localparam int CW        = $clog2(NCLK + NPINS);
   localparam int CB        = xp_cell_bits(SW, CW);
   localparam int OB        = xp_out_bits(SW, CW);
   localparam int TOTAL     = NPINS * CB;
   localparam int ICLK_LSB  = OB;
   localparam int IMODE_LSB = OB + CW;

   if (NPINS < 2) begin : g_bad_pins
      $error("xpt_fabric: NPINS must be at least 2");
   end
   if (NCLK < 1) begin : g_bad_clks
      $error("xpt_fabric: NCLK must be at least 1");
   end

   logic [TOTAL-1:0]      cfg_shadow, cfg_act;
   logic                  cfg_valid;
   logic [NCLK+NPINS-1:0] clk_pool;
   logic [NPINS-1:0]      pool;

   assign clk_pool = {pin_in, dclk};

   xpt_cfg_chain #(.TOTAL(TOTAL)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_en  (cfg_en),
      .cfg_din (cfg_din),
      .shadow  (cfg_shadow),
      .active  (cfg_act),
      .valid   (cfg_valid)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [CB-1:0] cell_cfg;
      logic [CW-1:0] iclk;
      logic          igate;

      assign cell_cfg = cfg_act[i * CB +: CB];
      assign iclk     = cell_cfg[ICLK_LSB +: CW];
      assign igate    = (32'(iclk) < NCLK + NPINS) ? clk_pool[iclk] : 1'b0;

      xpt_stage u_istage (
         .clk   (clk),
         .rst_n (rst_n),
         .mode  (cell_cfg[IMODE_LSB +: 2]),
         .gate  (igate),
         .d     (pin_in[i]),
         .q     (pool[i])
      );

      xpt_out_cell #(.NPINS(NPINS), .NCLK(NCLK)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg      (cell_cfg[OB-1:0]),
         .pool     (pool),
         .clk_pool (clk_pool),
         .valid    (cfg_valid),
         .out      (pin_out[i]),
         .oe       (pin_oe[i])
      );
   end
endmodule

// File: rtl/xpt_fabric_chk.sv
`timescale 1ns/1ps
module xpt_fabric_chk #(
   parameter int NPINS = 8,
   parameter int SW    = 3,
   parameter int CB    = 37,
   parameter int TOTAL = 296
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_en,
   input logic [NPINS-1:0] pin_out,
   input logic [NPINS-1:0] pin_oe,
   input logic [TOTAL-1:0] cfg_shadow,
   input logic [TOTAL-1:0] cfg_act,
   input logic             cfg_valid
);
   logic en_seen_q, loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_seen_q <= 1'b0;
         loaded_q  <= 1'b0;
      end else begin
         en_seen_q <= cfg_en;
         if (en_seen_q && !cfg_en) loaded_q <= 1'b1;
      end
   end

   // R7: no pin driven before the first transfer
   a_r7_hiz_until_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded_q |-> (pin_oe == '0));

   // R8: transfer copies the shadow frame
   a_r8_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      (en_seen_q && !cfg_en) |=> (cfg_act == $past(cfg_shadow)));

   // R9: active frame untouched while shifting
   a_r9_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_en |=> $stable(cfg_act));

   for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
      // R3: forced high level
      a_r3_fix_high: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_act[i * CB + 2 + SW +: 2] == 2'b11) |-> pin_out[i]);
      // R3: forced low level
      a_r3_fix_low: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_act[i * CB + 2 + SW +: 2] == 2'b10) |-> !pin_out[i]);
      // R6: constant enable drives the pin once configured
      a_r6_const_oe: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_valid && cfg_act[i * CB + 1]) |-> pin_oe[i]);
   end
endmodule

bind xpt_fabric xpt_fabric_chk #(
   .NPINS (NPINS),
   .SW    (SW),
   .CB    (CB),
   .TOTAL (TOTAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_en     (cfg_en),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .cfg_shadow (cfg_shadow),
   .cfg_act    (cfg_act),
   .cfg_valid  (cfg_valid)
);

// File: tb/xpt_fabric_bench.sv
`timescale 1ns/1ps
module xpt_fabric_bench;
   localparam int N   = 8;
   localparam int NC  = 2;
   localparam int CB  = 37;
   localparam int TOT = N * CB;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_en = 1'b0;
   logic         cfg_din = 1'b0;
   logic [NC-1:0] dclk = '0;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out, pin_oe;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   xpt_fabric u_xpt_fabric (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
      .dclk(dclk), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // active model configuration (m_) and next frame (n_)
   int m_imode[N], m_iclk[N], m_omode[N], m_oclk[N], m_sel0[N], m_sel1[N];
   int m_fix[N], m_oesrc[N], m_oec[N], m_oep[N], m_src[N][4];
   int n_imode[N], n_iclk[N], n_omode[N], n_oclk[N], n_sel0[N], n_sel1[N];
   int n_fix[N], n_oesrc[N], n_oec[N], n_oep[N], n_src[N][4];
   bit m_valid = 1'b0;
   bit m_en_q  = 1'b0;

   // model stage state: index 0 input stage, 1 output stage
   bit st_hold[2][N], st_gq[2][N], st_cap[2][N];
   bit cur_g[2][N], cur_d[2][N];

   function automatic bit gate_of(int k);
      if (k < NC) return dclk[k];
      if (k < NC + N) return pin_in[k - NC];
      return 1'b0;
   endfunction

   function automatic bit stage_of(int mode, bit g, bit d, bit hold, bit cap);
      if (mode == 1) return g ? d : hold;
      if (mode == 2) return cap;
      return d;
   endfunction

   task automatic check_now();
      bit pool[N];
      bit eo, eoe, s;
      int way;
      for (int i = 0; i < N; i++) begin
         cur_g[0][i] = gate_of(m_iclk[i]);
         cur_d[0][i] = pin_in[i];
         pool[i] = stage_of(m_imode[i], cur_g[0][i], pin_in[i], st_hold[0][i], st_cap[0][i]);
      end
      for (int i = 0; i < N; i++) begin
         way = 2 * int'(pool[m_sel1[i]]) + int'(pool[m_sel0[i]]);
         cur_d[1][i] = pool[m_src[i][way]];
         cur_g[1][i] = gate_of(m_oclk[i]);
         s = stage_of(m_omode[i], cur_g[1][i], cur_d[1][i], st_hold[1][i], st_cap[1][i]);
         eo = (m_fix[i] == 3) ? 1'b1 : (m_fix[i] == 2) ? 1'b0 : s;
         eoe = m_valid && ((m_oec[i] != 0) || (pool[m_oesrc[i]] ^ (m_oep[i] != 0)));
         vectors++;
         if (pin_oe[i] !== eoe) begin
            errors++;
            $display("FAIL %s pin %0d oe: actual %b expected %b",
                     m_valid ? "R6 R8 R9" : "R7", i, pin_oe[i], eoe);
         end
         vectors++;
         if (pin_out[i] !== eo) begin
            errors++;
            $display("FAIL %s pin %0d out: actual %b expected %b",
                     (m_fix[i] >= 2) ? "R3" : "R1 R2 R4 R5", i, pin_out[i], eo);
         end
      end
   endtask

   task automatic apply_frame();
      for (int i = 0; i < N; i++) begin
         m_imode[i] = n_imode[i]; m_iclk[i] = n_iclk[i];
         m_omode[i] = n_omode[i]; m_oclk[i] = n_oclk[i];
         m_sel0[i] = n_sel0[i];   m_sel1[i] = n_sel1[i];
         m_fix[i] = n_fix[i];     m_oesrc[i] = n_oesrc[i];
         m_oec[i] = n_oec[i];     m_oep[i] = n_oep[i];
         for (int k = 0; k < 4; k++) m_src[i][k] = n_src[i][k];
      end
   endtask

   // one cycle: drive, compare mid-cycle, update model after the edge
   task automatic cyc(input bit en, input bit din);
      @(negedge clk);
      cfg_en  = en;
      cfg_din = din;
      pin_in  = N'($urandom);
      dclk    = NC'($urandom);
      #1;
      check_now();
      @(posedge clk);
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < N; i++) begin
            if (cur_g[s][i]) st_hold[s][i] = cur_d[s][i];
            if (cur_g[s][i] && !st_gq[s][i]) st_cap[s][i] = cur_d[s][i];
            st_gq[s][i] = cur_g[s][i];
         end
      if (m_en_q && !en) begin
         apply_frame();
         m_valid = 1'b1;
      end
      m_en_q = en;
   endtask

   // R8: frame packing, shifted MSB first
   task automatic load_frame();
      logic [TOT-1:0] v;
      v = '0;
      for (int i = 0; i < N; i++) begin
         int b;
         b = i * CB;
         v[b]        = n_oep[i][0];
         v[b + 1]    = n_oec[i][0];
         v[b + 2 +: 3]  = n_oesrc[i][2:0];
         v[b + 5 +: 2]  = n_fix[i][1:0];
         v[b + 7 +: 4]  = n_oclk[i][3:0];
         v[b + 11 +: 2] = n_omode[i][1:0];
         v[b + 13 +: 3] = n_sel0[i][2:0];
         v[b + 16 +: 3] = n_sel1[i][2:0];
         for (int k = 0; k < 4; k++) v[b + 19 + 3 * k +: 3] = n_src[i][k][2:0];
         v[b + 31 +: 4] = n_iclk[i][3:0];
         v[b + 35 +: 2] = n_imode[i][1:0];
      end
      for (int b = TOT - 1; b >= 0; b--) cyc(1'b1, v[b]);
      cyc(1'b0, 1'b0);
   endtask

   task automatic frame_random(input int fix_bias);
      for (int i = 0; i < N; i++) begin
         n_imode[i] = int'($urandom % 4); n_omode[i] = int'($urandom % 4);
         n_iclk[i]  = int'($urandom % 16); n_oclk[i] = int'($urandom % 16);
         n_sel0[i]  = int'($urandom % 8);  n_sel1[i] = int'($urandom % 8);
         n_fix[i]   = (int'($urandom % 4) < fix_bias) ? 2 + int'($urandom % 2)
                                                      : int'($urandom % 2);
         n_oesrc[i] = int'($urandom % 8);
         n_oec[i]   = int'($urandom % 2); n_oep[i] = int'($urandom % 2);
         for (int k = 0; k < 4; k++) n_src[i][k] = int'($urandom % 8);
      end
   endtask

   task automatic run(input int n);
      for (int c = 0; c < n; c++) cyc(1'b0, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_imode[i] = 0; m_iclk[i] = 0; m_omode[i] = 0; m_oclk[i] = 0;
         m_sel0[i] = 0; m_sel1[i] = 0; m_fix[i] = 0; m_oesrc[i] = 0;
         m_oec[i] = 0; m_oep[i] = 0;
         for (int k = 0; k < 4; k++) m_src[i][k] = 0;
         for (int s = 0; s < 2; s++) begin
            st_hold[s][i] = 1'b0; st_gq[s][i] = 1'b0; st_cap[s][i] = 1'b0;
         end
      end
      repeat (3) @(negedge clk);
      // R7: reset state, all pins undriven
      vectors++;
      if (pin_oe !== '0) begin
         errors++;
         $display("FAIL R7 reset oe: actual %b expected %b", pin_oe, {N{1'b0}});
      end
      rst_n = 1'b1;
      run(20);

      // R1: straight rotation, constant enable, pass-through stages
      for (int i = 0; i < N; i++) begin
         n_imode[i] = 0; n_omode[i] = 3; n_iclk[i] = 0; n_oclk[i] = 0;
         n_sel0[i] = 0; n_sel1[i] = 0; n_fix[i] = 1; n_oesrc[i] = 0;
         n_oec[i] = 1; n_oep[i] = 0;
         for (int k = 0; k < 4; k++) n_src[i][k] = (i + 1) % N;
      end
      load_frame();
      run(40);

      // R3: alternating forced levels; R6: routed enable, both polarities
      for (int i = 0; i < N; i++) begin
         n_fix[i] = 2 + (i % 2);
         n_oec[i] = 0; n_oep[i] = i % 2; n_oesrc[i] = (i + 3) % N;
      end
      load_frame();
      run(40);

      // R2, R4, R5: latches and registers on dedicated and pin clocks
      for (int i = 0; i < N; i++) begin
         n_fix[i] = 0; n_oec[i] = 1;
         n_imode[i] = 1 + (i % 2); n_omode[i] = 2 - (i % 2);
         n_iclk[i] = i % 10; n_oclk[i] = (i + 5) % 16;
         n_sel0[i] = (i + 1) % N; n_sel1[i] = (i + 2) % N;
         for (int k = 0; k < 4; k++) n_src[i][k] = (i + k * 3) % N;
      end
      load_frame();
      run(60);

      // R9 and all: random frames, each loaded over a live configuration
      for (int f = 0; f < 30; f++) begin
         frame_random(f % 3);
         load_frame();
         run(60);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule